// File: doc/BRIEF.md
# Sequential Board Identification Byte Port

This block is a bus slave that exposes an identification and diagnostic byte image held in an external SPI serial EEPROM. Two locations are decoded: a data location at `BASE` and a pointer-clear location at `BASE + 2`. Software rewinds the port by writing the clear location. Each read of the data location then returns the next image byte, so the board identifier comes first, followed by the diagnostic code. The block keeps a 10-bit byte pointer, runs one SPI read transaction per data read, and holds the bus cycle open until the byte has arrived.

The bus side is a valid/ready handshake. The master raises `bus_req` with `bus_we` and `bus_addr` and holds all three stable until `bus_ack` is seen high. `bus_ack` is a single-cycle pulse. The master must drop `bus_req`, or move on to a different request, in the cycle after the pulse. The slave applies back-pressure by keeping `bus_ack` low for as long as it needs, which is the length of a full serial fetch on a data read. A write carries no data, because the value written has no effect.

Top module: `idrom_port`

## Requirements
- R1: A write to `BASE + 2` sets the byte pointer to 0 and is acknowledged one cycle after it is sampled. No SPI transaction takes place.
- R2: A read at `BASE` returns the image byte at the pointer on `bus_rdata` during the `bus_ack` cycle. The pointer then advances by one, so successive reads return successive bytes.
- R3: After reset, the first two data reads return image bytes 0 and 1. These are the board identifier, octal 034 followed by 000 for a memory board.
- R4: On a data read, `bus_ack` rises only after the SPI transaction has completed and chip select has returned high. `bus_ack` is never high for two cycles in a row.
- R5: Each fetch holds `spi_cs_n` low for exactly 32 SCLK pulses in SPI mode 0, most significant bit first. The 32 bits are opcode 0x03, then a 16-bit byte address whose upper 6 bits are 0 and whose lower 10 bits are the pointer, then 8 data bits sampled from `spi_miso`.
- R6: The pointer wraps from 1023 to 0, so read 1025 after a clear returns image byte 0.
- R7: A write to `BASE` is acknowledged and has no effect on the pointer.
- R8: A request to any address other than `BASE` or `BASE + 2` is never acknowledged and starts no SPI activity.
- R9: A read of `BASE + 2` is acknowledged one cycle after it is sampled, returns 0, and leaves the pointer unchanged.
- R10: Reset clears the pointer to 0, drives `spi_cs_n` high and `spi_sclk` low, and holds `bus_ack` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Request valid; held until `bus_ack` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address of the request |
| bus_rdata | output | 8 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | One-cycle acknowledge (ready) |
| spi_cs_n | output | 1 | EEPROM chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_miso | input | 1 | Serial data from the EEPROM |

## Verification
The bench reads the whole 1 KiB image in order against a serial EEPROM model, then makes one more read. A pointer with the wrong width or a broken increment would show up as a wrong byte, either somewhere in the sweep or on the wrap read. For every fetch, the model checks the opcode, the address and the pulse count. An acknowledge raised before chip select returns high would hand the master a byte that has not finished arriving. Pointer clears are issued in the middle of the stream, together with writes to the data location and reads of the clear location. A decoder that mixed these up would either rewind the stream or skip a byte. Requests to neighbouring addresses are held for a long time to show that nothing responds to them.

// File: rtl/idrom_pkg.sv
package idrom_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ACK
  } port_state_e;

  localparam logic [7:0] SPI_READ_OP = 8'h03;
  localparam int         SPI_ADDR_W  = 16;
  localparam int         SPI_FRAME   = 32;
endpackage

// File: rtl/idrom_decode.sv
module idrom_decode #(
  parameter int             AW   = 16,
  parameter logic [AW-1:0]  BASE = 16'hF000
) (
  input  logic [AW-1:0] addr,
  output logic          hit_data,
  output logic          hit_clr
);
  localparam logic [AW-1:0] CLR_ADDR = BASE + AW'(2);

  always_comb begin
    hit_data = (addr == BASE);
    hit_clr  = (addr == CLR_ADDR);
  end
endmodule

// File: rtl/idrom_ptr.sv
module idrom_ptr #(
  parameter int PTR_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst || clr) ptr <= '0;
    else if (inc)   ptr <= ptr + PTR_W'(1);
  end

  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ptr == '0)); // R1
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |=> (ptr == $past(ptr) + PTR_W'(1))); // R6
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr) |=> $stable(ptr)); // R7
endmodule

// File: rtl/idrom_spi.sv
module idrom_spi
  import idrom_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [SPI_ADDR_W-1:0] addr,
  input  logic                  miso,
  output logic                  sclk,
  output logic                  cs_n,
  output logic                  mosi,
  output logic [7:0]            rx_byte,
  output logic                  done
);
  localparam int DIV_W  = $clog2(CLK_DIV) + 1;
  localparam int HDR_W  = 8 + SPI_ADDR_W;
  localparam int CNT_W  = $clog2(SPI_FRAME);

  logic [HDR_W-1:0] hdr;
  logic [CNT_W-1:0] bitcnt;
  logic [DIV_W-1:0] div;
  logic             busy;

  assign mosi = hdr[HDR_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      hdr     <= '0;
      bitcnt  <= '0;
      div     <= '0;
      rx_byte <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          cs_n   <= 1'b0;
          sclk   <= 1'b0;
          hdr    <= {SPI_READ_OP, addr};
          bitcnt <= '0;
          div    <= '0;
        end
      end else if (div == DIV_W'(CLK_DIV - 1)) begin
        div <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          if (bitcnt >= CNT_W'(HDR_W)) rx_byte <= {rx_byte[6:0], miso};
        end else begin
          sclk <= 1'b0;
          hdr  <= {hdr[HDR_W-2:0], 1'b0};
          if (bitcnt == CNT_W'(SPI_FRAME - 1)) begin
            busy <= 1'b0;
            cs_n <= 1'b1;
            done <= 1'b1;
          end else begin
            bitcnt <= bitcnt + CNT_W'(1);
          end
        end
      end else begin
        div <= div + DIV_W'(1);
      end
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk); // R5
  AST_CS_RISE_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> done); // R5
  AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy); // R5
endmodule

// File: rtl/idrom_port.sv
module idrom_port
  import idrom_pkg::*;
#(
  parameter int            AW      = 16,
  parameter logic [AW-1:0] BASE    = 16'hF000,
  parameter int            PTR_W   = 10,
  parameter int            CLK_DIV = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_rdata,
  output logic          bus_ack,
  output logic          spi_cs_n,
  output logic          spi_sclk,
  output logic          spi_mosi,
  input  logic          spi_miso
);
  localparam int PAD_W = SPI_ADDR_W - PTR_W;

  port_state_e      state;
  logic             hit_data, hit_clr;
  logic             take, fetch_go, ptr_clr, ptr_inc;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       spi_byte;
  logic             spi_done;

  idrom_decode #(.AW(AW), .BASE(BASE)) u_dec (
    .addr(bus_addr), .hit_data(hit_data), .hit_clr(hit_clr)
  );

  always_comb begin
    take     = (state == ST_IDLE) && bus_req && (hit_data || hit_clr);
    fetch_go = take && hit_data && !bus_we;
    ptr_clr  = take && hit_clr && bus_we;
    ptr_inc  = (state == ST_FETCH) && spi_done;
  end

  idrom_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .clr(ptr_clr), .inc(ptr_inc), .ptr(ptr)
  );

  idrom_spi #(.CLK_DIV(CLK_DIV)) u_spi (
    .clk(clk), .rst(rst), .start(fetch_go),
    .addr({{PAD_W{1'b0}}, ptr}), .miso(spi_miso),
    .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .rx_byte(spi_byte), .done(spi_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_rdata <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (fetch_go) begin
            state <= ST_FETCH;
          end else if (take) begin
            state <= ST_ACK;
            if (!bus_we) bus_rdata <= '0;
          end
        end
        ST_FETCH: begin
          if (spi_done) begin
            bus_rdata <= spi_byte;
            state     <= ST_ACK;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bus_ack = (state == ST_ACK);

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack); // R4
  AST_FETCH_ACK_AFTER_SPI: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH && spi_done) |=> (bus_ack && spi_cs_n)); // R4
  AST_IDLE_NO_SPI: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> spi_cs_n); // R8
  AST_FETCH_NOT_ACKED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |-> !bus_ack); // R4
endmodule

// File: tb/sim_idrom_port.sv
module sim_idrom_port;
  localparam logic [15:0] BASE = 16'hF000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_rdata;
  logic        bus_ack;
  logic        spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;

  int nvec = 0;
  int nbad = 0;

  always #5 clk = ~clk;

  idrom_port #(.AW(16), .BASE(BASE), .PTR_W(10), .CLK_DIV(1)) u0 (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  function automatic logic [7:0] img(input int a);
    if (a == 0) return 8'o034;
    if (a == 1) return 8'o000;
    return 8'((a * 37) ^ (a >> 3) ^ 8'h5A);
  endfunction

  // serial EEPROM model, mode 0
  int          nrise = 0;
  logic [23:0] hdr = '0;
  int          xfers = 0;
  int          bad_frames = 0;
  logic [15:0] last_addr = '0;
  bit          xfer_done = 1'b0;

  always @(negedge spi_cs_n) begin
    nrise = 0;
  end
  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      if (nrise < 24) hdr = {hdr[22:0], spi_mosi};
      nrise++;
    end
  end
  always @(negedge spi_sclk) begin
    if (!spi_cs_n && nrise >= 24 && nrise < 32) begin
      logic [7:0] b;
      b = img(int'(hdr[9:0]));
      spi_miso = b[31 - nrise];
    end
  end
  always @(posedge spi_cs_n) begin
    if (nrise > 0) begin
      xfers++;
      last_addr = hdr[15:0];
      if (nrise != 32 || hdr[23:16] != 8'h03 || hdr[15:10] != 6'd0) bad_frames++;
      else xfer_done = 1'b1;
      nrise = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // issue one request, return data and cycles to ack (-1 if none within limit)
  task automatic xact(input bit we, input logic [15:0] a, input int limit,
                      output logic [7:0] d, output int cyc);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a;
    cyc = -1;
    d = '0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (bus_ack) begin
        cyc = i + 1;
        d = bus_rdata;
        break;
      end
    end
    bus_req = 1'b0;
  endtask

  task automatic rd_data(input int exp_idx, input string req);
    logic [7:0] d;
    int c;
    int x0;
    x0 = xfers;
    xfer_done = 1'b0;
    xact(1'b0, BASE, 400, d, c);
    chk(c > 0, "R4", c, 1);
    chk(xfer_done && spi_cs_n, "R4", int'(xfer_done), 1);
    chk(xfers == x0 + 1, "R5", xfers - x0, 1);
    chk(last_addr == 16'(exp_idx), "R5", int'(last_addr), exp_idx);
    chk(d == img(exp_idx), req, int'(d), int'(img(exp_idx)));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int c, x0;
    repeat (4) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R10", int'(spi_cs_n), 1);
    chk(spi_sclk == 1'b0, "R10", int'(spi_sclk), 0);
    chk(bus_ack == 1'b0, "R10", int'(bus_ack), 0);
    rst = 1'b0;

    // identifier bytes straight after reset
    rd_data(0, "R3");
    rd_data(1, "R3");
    // sweep the rest of the image
    for (int k = 2; k < 1024; k++) rd_data(k, "R2");
    // wrap
    rd_data(0, "R6");

    // read of clear location: zero, pointer unchanged
    x0 = xfers;
    xact(1'b0, BASE + 16'd2, 20, d, c);
    chk(c == 1, "R9", c, 1);
    chk(d == 8'h00, "R9", int'(d), 0);
    chk(xfers == x0, "R9", xfers - x0, 0);
    rd_data(1, "R9");

    // clear in mid-stream
    rd_data(2, "R2");
    x0 = xfers;
    xact(1'b1, BASE + 16'd2, 20, d, c);
    chk(c == 1, "R1", c, 1);
    chk(xfers == x0, "R1", xfers - x0, 0);
    rd_data(0, "R1");

    // write to data location ignored
    rd_data(1, "R2");
    rd_data(2, "R2");
    xact(1'b1, BASE, 20, d, c);
    chk(c == 1, "R7", c, 1);
    rd_data(3, "R7");

    // back-to-back clears
    xact(1'b1, BASE + 16'd2, 20, d, c);
    xact(1'b1, BASE + 16'd2, 20, d, c);
    chk(c == 1, "R1", c, 1);
    rd_data(0, "R1");

    // foreign addresses
    foreach (BASE[i]) begin end
    x0 = xfers;
    xact(1'b0, BASE + 16'd4, 200, d, c);
    chk(c == -1, "R8", c, -1);
    xact(1'b1, BASE - 16'd2, 200, d, c);
    chk(c == -1, "R8", c, -1);
    xact(1'b0, BASE + 16'd1, 200, d, c);
    chk(c == -1, "R8", c, -1);
    chk(xfers == x0 && spi_cs_n, "R8", xfers - x0, 0);
    rd_data(1, "R8");

    chk(bad_frames == 0, "R5", bad_frames, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule